// File: doc/BRIEF.md
# Lane-Split Saturating Pack Unit

This block narrows two vectors of eight signed 32-bit elements, A and B, into a single vector of sixteen signed 16-bit elements. Each element is clamped to the signed 16-bit range on the way down. The result is held in an output register.

The default arrangement works on two independent 128-bit lanes. Each lane packs its four A elements and then its four B elements, so the output runs A0..A3, B0..B3, A4..A7, B4..B7. This is not the concatenation that a reader might expect. When the reorder control is set, a fixed permutation of 32-bit pairs runs before the register and restores the plain order: all A elements, then all B elements.

The main use is to merge two 32-bit compare masks (every element all-ones or all-zeros) into one 16-bit-per-element mask that a later stage can scan for its first set element. Because all-ones packs to all-ones, such masks pass through unchanged.

Top module: `lane_pack_unit`

## Requirements
- R1: While rst is high at a clock edge, out_valid and out_vec are zero after that edge.
- R2: Each element is narrowed with signed saturation. An input above 32767 gives 16'h7FFF. An input below -32768 gives 16'h8000. An input in range keeps its low 16 bits, so 32767 gives 16'h7FFF and -32768 gives 16'h8000.
- R3: An input element of -1 (32'hFFFFFFFF) gives 16'hFFFF. An all-ones A and B therefore give an all-ones out_vec in either order mode.
- R4: With reorder_en low, output slot k (out_vec[16k+15:16k]) is filled as follows: slots 0-3 from A0-A3, slots 4-7 from B0-B3, slots 8-11 from A4-A7, slots 12-15 from B4-B7. Input element i is a_vec/b_vec[32i+31:32i].
- R5: With reorder_en high, slots 0-7 hold A0-A7 and slots 8-15 hold B0-B7. This is the lane result taken as eight 32-bit words in the source order 0,1,4,5,2,3,6,7.
- R6: out_valid is high one cycle after each cycle in which in_valid is high, and low one cycle after each cycle in which in_valid is low.
- R7: While in_valid is low, out_vec holds its value. Changes on a_vec, b_vec or reorder_en in those cycles have no effect on it.
- R8: reorder_en is taken in the same cycle as the data it applies to. Back-to-back captures in different modes each give their own ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture a_vec, b_vec and reorder_en at this edge |
| reorder_en | input | 1 | 0: lane-interleaved order, 1: natural A-then-B order |
| a_vec | input | 256 | Eight signed 32-bit elements A0..A7 |
| b_vec | input | 256 | Eight signed 32-bit elements B0..B7 |
| out_vec | output | 256 | Sixteen signed 16-bit packed elements |
| out_valid | output | 1 | out_vec was loaded at the previous edge |

## Verification
The assertions check on every cycle that:
- the valid flag trails in_valid by one cycle;
- the output register holds while in_valid is low;
- reset clears the output;
- the all-ones case packs to all-ones;
- A0 saturates correctly at both limits;
- an in-range B0 lands in slot 4 in lane order and in slot 8 in natural order.

The full slot map across all sixteen slots can only be shown by the bench's scenarios. The same applies to the boundary values on every element position and to mode switches between back-to-back captures. The bench compares each of these against a model written from the requirements.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;
  typedef enum logic {
    ORDER_LANE    = 1'b0,
    ORDER_NATURAL = 1'b1
  } order_mode_e;
endpackage

// File: rtl/sat_narrow.sv
module sat_narrow #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int TOP_W = IN_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

  logic [TOP_W-1:0] top_bits;
  logic             fits;

  assign top_bits = din[IN_W-1:OUT_W-1];
  assign fits     = (top_bits == '0) || (top_bits == '1);

  always_comb begin
    if (fits)                dout = din[OUT_W-1:0];
    else if (din[IN_W-1])    dout = NEG_LIM;
    else                     dout = POS_LIM;
  end
endmodule

// File: rtl/lane_interleave.sv
module lane_interleave #(
  parameter int OUT_W   = 16,
  parameter int ELEMS   = 8,
  parameter int LANE_IN = 4
) (
  input  logic [ELEMS*OUT_W-1:0]   a_nar,
  input  logic [ELEMS*OUT_W-1:0]   b_nar,
  output logic [2*ELEMS*OUT_W-1:0] lane_out
);
  localparam int LANES = ELEMS / LANE_IN;
  localparam int SLOTS = 2 * LANE_IN;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar j = 0; j < LANE_IN; j++) begin : g_elem
      assign lane_out[(l*SLOTS + j)*OUT_W +: OUT_W] =
             a_nar[(l*LANE_IN + j)*OUT_W +: OUT_W];
      assign lane_out[(l*SLOTS + LANE_IN + j)*OUT_W +: OUT_W] =
             b_nar[(l*LANE_IN + j)*OUT_W +: OUT_W];
    end
  end
endmodule

// File: rtl/order_restore.sv
module order_restore #(
  parameter int OUT_W   = 16,
  parameter int ELEMS   = 8,
  parameter int LANE_IN = 4
) (
  input  logic [2*ELEMS*OUT_W-1:0] lane_in,
  input  logic                     natural,
  output logic [2*ELEMS*OUT_W-1:0] vec_out
);
  localparam int SLOTS = 2 * LANE_IN;
  localparam int VW    = 2 * ELEMS * OUT_W;

  logic [VW-1:0] nat_vec;

  for (genvar k = 0; k < ELEMS; k++) begin : g_dst
    localparam int LN  = k / LANE_IN;
    localparam int POS = k % LANE_IN;
    localparam int SA  = LN*SLOTS + POS;
    localparam int SB  = LN*SLOTS + LANE_IN + POS;
    assign nat_vec[k*OUT_W +: OUT_W]         = lane_in[SA*OUT_W +: OUT_W];
    assign nat_vec[(ELEMS+k)*OUT_W +: OUT_W] = lane_in[SB*OUT_W +: OUT_W];
  end

  assign vec_out = natural ? nat_vec : lane_in;
endmodule

// File: rtl/lane_pack_unit.sv
module lane_pack_unit
  import lane_pack_pkg::*;
#(
  parameter int IN_W      = 32,
  parameter int OUT_W     = 16,
  parameter int ELEMS     = 8,
  parameter int LANE_BITS = 128
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       reorder_en,
  input  logic [ELEMS*IN_W-1:0]      a_vec,
  input  logic [ELEMS*IN_W-1:0]      b_vec,
  output logic [2*ELEMS*OUT_W-1:0]   out_vec,
  output logic                       out_valid
);
  localparam int LANE_IN = LANE_BITS / IN_W;
  localparam int NW      = ELEMS * OUT_W;
  localparam int VW      = 2 * NW;

  order_mode_e   mode;
  logic [NW-1:0] a_nar, b_nar;
  logic [VW-1:0] lane_vec, next_vec;

  assign mode = order_mode_e'(reorder_en);

  for (genvar i = 0; i < ELEMS; i++) begin : g_sat
    sat_narrow #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat_a (
      .din (a_vec[i*IN_W +: IN_W]),
      .dout(a_nar[i*OUT_W +: OUT_W])
    );
    sat_narrow #(.IN_W(IN_W), .OUT_W(OUT_W)) u_sat_b (
      .din (b_vec[i*IN_W +: IN_W]),
      .dout(b_nar[i*OUT_W +: OUT_W])
    );
  end

  lane_interleave #(.OUT_W(OUT_W), .ELEMS(ELEMS), .LANE_IN(LANE_IN)) u_lane (
    .a_nar   (a_nar),
    .b_nar   (b_nar),
    .lane_out(lane_vec)
  );

  order_restore #(.OUT_W(OUT_W), .ELEMS(ELEMS), .LANE_IN(LANE_IN)) u_restore (
    .lane_in(lane_vec),
    .natural(mode == ORDER_NATURAL),
    .vec_out(next_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vec   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= next_vec;
    end
  end
endmodule

// File: rtl/lane_pack_chk.sv
module lane_pack_chk #(
  parameter int IN_W      = 32,
  parameter int OUT_W     = 16,
  parameter int ELEMS     = 8,
  parameter int LANE_BITS = 128
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     reorder_en,
  input logic [ELEMS*IN_W-1:0]    a_vec,
  input logic [ELEMS*IN_W-1:0]    b_vec,
  input logic [2*ELEMS*OUT_W-1:0] out_vec,
  input logic                     out_valid
);
  localparam int LANE_IN = LANE_BITS / IN_W;
  localparam logic signed [IN_W-1:0] HI = (IN_W'(1) <<< (OUT_W-1)) - 1;
  localparam logic signed [IN_W-1:0] LO = -(IN_W'(1) <<< (OUT_W-1));
  localparam logic [OUT_W-1:0] SAT_HI = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] SAT_LO = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] a0, b0;
  logic                   b0_fits;
  assign a0 = $signed(a_vec[IN_W-1:0]);
  assign b0 = $signed(b_vec[IN_W-1:0]);
  assign b0_fits = (b0 <= HI) && (b0 >= LO);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vec == '0));

  p_sat_high_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a0 > HI) |=> out_vec[OUT_W-1:0] == SAT_HI);

  p_sat_low_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a0 < LO) |=> out_vec[OUT_W-1:0] == SAT_LO);

  p_ones_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && a_vec == '1 && b_vec == '1) |=> out_vec == '1);

  p_lane_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !reorder_en && b0_fits) |=>
      out_vec[LANE_IN*OUT_W +: OUT_W] == $past(b_vec[OUT_W-1:0]));

  p_natural_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && reorder_en && b0_fits) |=>
      out_vec[ELEMS*OUT_W +: OUT_W] == $past(b_vec[OUT_W-1:0]));

  p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_fall_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec));
endmodule

bind lane_pack_unit lane_pack_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .ELEMS(ELEMS), .LANE_BITS(LANE_BITS)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .reorder_en(reorder_en),
  .a_vec(a_vec), .b_vec(b_vec), .out_vec(out_vec), .out_valid(out_valid)
);

// File: tb/tb_lane_pack_unit.sv
module tb_lane_pack_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         reorder_en = 1'b0;
  logic [255:0] a_vec = '0;
  logic [255:0] b_vec = '0;
  logic [255:0] out_vec;
  logic         out_valid;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lane_pack_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .reorder_en(reorder_en),
    .a_vec(a_vec), .b_vec(b_vec), .out_vec(out_vec), .out_valid(out_valid)
  );

  function automatic logic [15:0] sat16(input logic [31:0] v);
    if ($signed(v) > 32767)       return 16'h7FFF;
    else if ($signed(v) < -32768) return 16'h8000;
    else                          return v[15:0];
  endfunction

  function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                         input logic nat);
    logic [255:0] r;
    for (int k = 0; k < 16; k++) begin
      int src;
      bit from_a;
      if (nat) begin
        from_a = (k < 8);
        src    = from_a ? k : k - 8;
      end else begin
        from_a = ((k % 8) < 4);
        src    = (k / 8) * 4 + (k % 4);
      end
      r[k*16 +: 16] = from_a ? sat16(a[src*32 +: 32]) : sat16(b[src*32 +: 32]);
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [255:0] got, input logic [255:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: out_vec got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Drive one capture at a negedge; sample at the following negedge.
  task automatic capture(input logic [255:0] a, input logic [255:0] b, input logic nat);
    @(negedge clk);
    a_vec = a; b_vec = b; reorder_en = nat; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] rnd_elem();
    case ($urandom_range(0, 3))
      0:       return $urandom;
      1:       return 32'($urandom_range(0, 65535)) - 32'd32768;
      2:       return 32'($urandom_range(0, 200000)) - 32'd100000;
      default: return $urandom_range(0, 1) ? 32'hFFFFFFFF : 32'h0;
    endcase
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check_bit("R1 out_valid", out_valid, 1'b0);
    check_vec("R1 out_vec", out_vec, '0);
  endtask

  task automatic t_boundary();
    logic [31:0] bv [8] = '{32'hFFFF7FFF, 32'hFFFF8000, 32'h00007FFF, 32'h00008000,
                            32'h00000000, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000};
    logic [255:0] a, b;
    for (int i = 0; i < 8; i++) begin
      a[i*32 +: 32] = bv[i];
      b[i*32 +: 32] = bv[7-i];
    end
    capture(a, b, 1'b0);
    check_vec("R2 boundary lane order", out_vec, model(a, b, 1'b0));
    check_vec("R2 expected literal slot0..3",
              {192'b0, out_vec[63:0]}, {192'b0, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h8000});
    capture(a, b, 1'b1);
    check_vec("R2 boundary natural order", out_vec, model(a, b, 1'b1));
  endtask

  task automatic t_ones();
    capture('1, '1, 1'b0);
    check_vec("R3 all ones lane", out_vec, '1);
    capture('1, '0, 1'b1);
    check_vec("R3 ones A natural", out_vec, {128'b0, {128{1'b1}}});
    capture('1, '0, 1'b0);
    check_vec("R3 ones A lane", out_vec, {64'b0, {64{1'b1}}, 64'b0, {64{1'b1}}});
  endtask

  task automatic t_order_ids();
    logic [255:0] a, b;
    for (int i = 0; i < 8; i++) begin
      a[i*32 +: 32] = 32'(16'h0A00 + i);
      b[i*32 +: 32] = 32'(16'h0B00 + i);
    end
    capture(a, b, 1'b0);
    check_vec("R4 lane slot map", out_vec,
      {16'h0B07,16'h0B06,16'h0B05,16'h0B04,16'h0A07,16'h0A06,16'h0A05,16'h0A04,
       16'h0B03,16'h0B02,16'h0B01,16'h0B00,16'h0A03,16'h0A02,16'h0A01,16'h0A00});
    capture(a, b, 1'b1);
    check_vec("R5 natural slot map", out_vec,
      {16'h0B07,16'h0B06,16'h0B05,16'h0B04,16'h0B03,16'h0B02,16'h0B01,16'h0B00,
       16'h0A07,16'h0A06,16'h0A05,16'h0A04,16'h0A03,16'h0A02,16'h0A01,16'h0A00});
  endtask

  task automatic t_random(input logic nat, input int n);
    for (int t = 0; t < n; t++) begin
      logic [255:0] a, b;
      for (int i = 0; i < 8; i++) begin
        a[i*32 +: 32] = rnd_elem();
        b[i*32 +: 32] = rnd_elem();
      end
      capture(a, b, nat);
      check_vec(nat ? "R5 random natural" : "R4 random lane", out_vec, model(a, b, nat));
    end
  endtask

  task automatic t_valid();
    @(negedge clk);
    in_valid = 1'b1; a_vec = '0; b_vec = '0;
    @(negedge clk);
    check_bit("R6 valid after capture", out_valid, 1'b1);
    in_valid = 1'b0;
    @(negedge clk);
    check_bit("R6 valid drops", out_valid, 1'b0);
  endtask

  task automatic t_hold();
    logic [255:0] a, b, exp;
    for (int i = 0; i < 8; i++) begin
      a[i*32 +: 32] = 32'(i * 1000);
      b[i*32 +: 32] = -32'(i * 1000);
    end
    capture(a, b, 1'b0);
    exp = model(a, b, 1'b0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      a_vec = {8{32'h7FFFFFFF}}; b_vec = {8{32'h12345678}}; reorder_en = ~reorder_en;
    end
    @(negedge clk);
    check_vec("R7 hold while idle", out_vec, exp);
  endtask

  task automatic t_mode_switch();
    logic [255:0] a, b;
    for (int i = 0; i < 8; i++) begin
      a[i*32 +: 32] = 32'(i + 1);
      b[i*32 +: 32] = 32'(i + 101);
    end
    @(negedge clk);
    a_vec = a; b_vec = b; reorder_en = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check_vec("R8 first capture natural", out_vec, model(a, b, 1'b1));
    reorder_en = 1'b0;
    @(negedge clk);
    check_vec("R8 second capture lane", out_vec, model(a, b, 1'b0));
    reorder_en = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec("R8 third capture natural", out_vec, model(a, b, 1'b1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_boundary();
    t_ones();
    t_order_ids();
    t_random(1'b0, 40);
    t_random(1'b1, 40);
    t_valid();
    t_hold();
    t_mode_switch();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_bit("R1 valid cleared by reset", out_valid, 1'b0);
    check_vec("R1 vec cleared by reset", out_vec, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule